// File: doc/BRIEF.md
# Shared Work Queue Admission Port

This block is the single submission point of a device work queue that many software contexts use at once. Every submitter writes its work descriptor to the same port. The descriptor holds an operation code, a parameter address, a completion-record address, a 20-bit process address space identifier (PASID) and a flag that marks the PASID as valid. The PASID is the only thing that tells the submitters apart.

A submission is non-posted. The submitter gets no ready signal and never has to hold the strobe. Instead, one cycle later the block returns a status that says whether the descriptor was queued.

- Accepted descriptors go into a first-in first-out store that only the block tracks.
- A descriptor that finds no free slot is dropped with a retry status. The submitter can then send it again.
- A descriptor without a valid PASID is refused with an invalid status.

On the drain side, a consumer takes entries in arrival order over a valid/ready handshake. Each entry comes with its PASID.

The submit side is a one-cycle strobe with no back-pressure. The drain side follows valid/ready rules:

- `dq_valid` stays high while the queue holds an entry.
- The presented entry does not change while `dq_valid` is high and `dq_ready` is low.
- An entry leaves the queue on the rising edge where both are high.

Top module: `shared_wq`

## Requirements
- R1: A status (`st_valid` high for one cycle) appears exactly one clock after each cycle in which `sub_valid` is high, and never after a cycle without it.
- R2: The status code is 2 bits: 00 accepted, 01 retry, 10 invalid. A descriptor with a valid PASID and a free slot is answered 00 and queued.
- R3: A descriptor whose `sub_pasid_ok` is 0 is answered 10 and not queued, whatever the occupancy, including when the queue is full. The free count and the head entry are unchanged afterwards.
- R4: A descriptor with a valid PASID that meets a full queue with no drain in the same cycle is answered 01 and discarded. The free count stays 0 and the queue contents are unchanged.
- R5: When the queue is full and an entry drains in the same cycle as a valid submission, the submission is answered 00 and queued.
- R6: Entries drain in acceptance order. Every field comes out as it was submitted, with all 20 PASID bits intact.
- R7: `dq_valid` is high exactly when the queue is non-empty. While `dq_valid` is high and `dq_ready` is low, the presented entry holds steady. An entry is removed on each edge where both are high.
- R8: `free_slots` equals DEPTH minus the number of queued entries. It reflects an accept or a drain from the clock edge on which that event takes place.
- R9: After reset the queue is empty: `free_slots` = DEPTH, `dq_valid` = 0 and `st_valid` = 0. A reset in the middle of operation discards all queued entries.
- R10: A submission and a drain in the same cycle on a non-full queue both take effect, and the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_valid | input | 1 | Submission strobe, one cycle per descriptor |
| sub_pasid_ok | input | 1 | PASID-valid flag of the descriptor |
| sub_pasid | input | PASID_W | Submitter's address space identifier |
| sub_op | input | OP_W | Operation code |
| sub_param_addr | input | ADDR_W | Parameter block address |
| sub_cmpl_addr | input | ADDR_W | Completion record address |
| st_valid | output | 1 | Status strobe, one cycle after the submission |
| st_code | output | 2 | 00 accepted, 01 retry, 10 invalid |
| dq_valid | output | 1 | Head entry present |
| dq_ready | input | 1 | Consumer takes the head entry |
| dq_pasid | output | PASID_W | PASID of the head entry |
| dq_op | output | OP_W | Operation code of the head entry |
| dq_param_addr | output | ADDR_W | Parameter address of the head entry |
| dq_cmpl_addr | output | ADDR_W | Completion address of the head entry |
| free_slots | output | $clog2(DEPTH+1) | Number of free queue slots |

## Verification
The admission decision is tried on four kinds of input pattern:
- a valid descriptor into a queue with room;
- a valid descriptor into a full queue with and without a concurrent drain, which separates retry from the freed-slot accept;
- a descriptor without a valid PASID into an empty queue and into a full queue, which shows that the invalid answer wins over retry;
- cycles without a strobe, which must produce no status.

Drain patterns with a stalled and then released consumer show the ordering and whether the head entry is stable. Checking every field of each drained entry catches corruption of any bit. A reset taken while entries are queued shows that nothing survives it.

// File: rtl/swq_pkg.sv
package swq_pkg;
  typedef enum logic [1:0] {
    ST_ACCEPT  = 2'b00,
    ST_RETRY   = 2'b01,
    ST_INVALID = 2'b10
  } swq_status_e;
endpackage

// File: rtl/swq_gate.sv
// Admission decision for one submission cycle.
module swq_gate
  import swq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             sub_valid,
  input  logic             pasid_ok,
  input  logic [CNT_W-1:0] occupancy,
  input  logic             popping,
  output logic             push,
  output swq_status_e      verdict
);
  logic has_room;

  // A pop in the same cycle frees a slot for the incoming entry.
  assign has_room = (occupancy < CNT_W'(DEPTH)) || popping;

  always_comb begin
    push    = 1'b0;
    verdict = ST_ACCEPT;
    if (!pasid_ok) begin
      verdict = ST_INVALID;
    end else if (has_room) begin
      verdict = ST_ACCEPT;
      push    = sub_valid;
    end else begin
      verdict = ST_RETRY;
    end
  end
endmodule

// File: rtl/swq_store.sv
// FIFO storage with occupancy counter.
module swq_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic [CNT_W-1:0] occupancy
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [CNT_W-1:0] cnt_q;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata     = mem[rd_ptr];
  assign occupancy = cnt_q;
endmodule

// File: rtl/swq_resp.sv
// Registered status return, one cycle after the strobe.
module swq_resp
  import swq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sub_valid,
  input  swq_status_e verdict,
  output logic        st_valid,
  output logic [1:0]  st_code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_code  <= 2'b00;
    end else begin
      st_valid <= sub_valid;
      if (sub_valid) st_code <= verdict;
    end
  end
endmodule

// File: rtl/shared_wq.sv
module shared_wq
  import swq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int PASID_W = 20,
  parameter int OP_W    = 8,
  parameter int ADDR_W  = 64,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int DESC_W = PASID_W + OP_W + 2 * ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sub_valid,
  input  logic               sub_pasid_ok,
  input  logic [PASID_W-1:0] sub_pasid,
  input  logic [OP_W-1:0]    sub_op,
  input  logic [ADDR_W-1:0]  sub_param_addr,
  input  logic [ADDR_W-1:0]  sub_cmpl_addr,
  output logic               st_valid,
  output logic [1:0]         st_code,
  output logic               dq_valid,
  input  logic               dq_ready,
  output logic [PASID_W-1:0] dq_pasid,
  output logic [OP_W-1:0]    dq_op,
  output logic [ADDR_W-1:0]  dq_param_addr,
  output logic [ADDR_W-1:0]  dq_cmpl_addr,
  output logic [CNT_W-1:0]   free_slots
);
  logic [CNT_W-1:0]  occupancy;
  logic              push, pop;
  swq_status_e       verdict;
  logic [DESC_W-1:0] wdesc, rdesc;

  assign dq_valid = (occupancy != '0);
  assign pop      = dq_valid && dq_ready;
  assign wdesc    = {sub_pasid, sub_op, sub_param_addr, sub_cmpl_addr};

  swq_gate #(.DEPTH(DEPTH)) u_gate (
    .sub_valid (sub_valid),
    .pasid_ok  (sub_pasid_ok),
    .occupancy (occupancy),
    .popping   (pop),
    .push      (push),
    .verdict   (verdict)
  );

  swq_store #(.DEPTH(DEPTH), .WIDTH(DESC_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .wdata     (wdesc),
    .rdata     (rdesc),
    .occupancy (occupancy)
  );

  swq_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .sub_valid (sub_valid),
    .verdict   (verdict),
    .st_valid  (st_valid),
    .st_code   (st_code)
  );

  assign {dq_pasid, dq_op, dq_param_addr, dq_cmpl_addr} = rdesc;
  assign free_slots = CNT_W'(DEPTH) - occupancy;
endmodule

// File: rtl/shared_wq_chk.sv
module shared_wq_chk #(
  parameter int DEPTH   = 16,
  parameter int PASID_W = 20,
  parameter int OP_W    = 8,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sub_valid,
  input logic               sub_pasid_ok,
  input logic               st_valid,
  input logic [1:0]         st_code,
  input logic               dq_valid,
  input logic               dq_ready,
  input logic [PASID_W-1:0] dq_pasid,
  input logic [OP_W-1:0]    dq_op,
  input logic [CNT_W-1:0]   free_slots
);
  p_status_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |=> st_valid);
  p_status_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_valid |=> !st_valid);
  p_invalid_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && !sub_pasid_ok && !(dq_valid && dq_ready))
      |=> (st_code == 2'b10) && $stable(free_slots));
  p_retry_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && sub_pasid_ok && free_slots == '0 && !dq_ready)
      |=> (st_code == 2'b01) && (free_slots == '0));
  p_full_drain_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && sub_pasid_ok && free_slots == '0 && dq_valid && dq_ready)
      |=> st_code == 2'b00);
  p_head_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_valid && !dq_ready) |=> dq_valid && $stable(dq_pasid) && $stable(dq_op));
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    free_slots <= CNT_W'(DEPTH));
  p_accept_with_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && sub_pasid_ok && free_slots != '0) |=> st_code == 2'b00);
endmodule

bind shared_wq shared_wq_chk #(
  .DEPTH(DEPTH), .PASID_W(PASID_W), .OP_W(OP_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sub_valid    (sub_valid),
  .sub_pasid_ok (sub_pasid_ok),
  .st_valid     (st_valid),
  .st_code      (st_code),
  .dq_valid     (dq_valid),
  .dq_ready     (dq_ready),
  .dq_pasid     (dq_pasid),
  .dq_op        (dq_op),
  .free_slots   (free_slots)
);

// File: tb/sim_shared_wq.sv
`timescale 1ns/1ps
module sim_shared_wq;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sub_valid = 1'b0, sub_pasid_ok = 1'b0, dq_ready = 1'b0;
  logic [19:0] sub_pasid = '0;
  logic [7:0]  sub_op = '0;
  logic [63:0] sub_param_addr = '0, sub_cmpl_addr = '0;
  logic        st_valid, dq_valid;
  logic [1:0]  st_code;
  logic [19:0] dq_pasid;
  logic [7:0]  dq_op;
  logic [63:0] dq_param_addr, dq_cmpl_addr;
  logic [2:0]  free_slots;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  shared_wq #(.DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_pasid_ok(sub_pasid_ok),
    .sub_pasid(sub_pasid), .sub_op(sub_op), .sub_param_addr(sub_param_addr),
    .sub_cmpl_addr(sub_cmpl_addr), .st_valid(st_valid), .st_code(st_code),
    .dq_valid(dq_valid), .dq_ready(dq_ready), .dq_pasid(dq_pasid), .dq_op(dq_op),
    .dq_param_addr(dq_param_addr), .dq_cmpl_addr(dq_cmpl_addr), .free_slots(free_slots)
  );

  typedef struct packed {
    logic        sub;
    logic        ok;
    logic        rdy;
    logic [19:0] pasid;
    logic [1:0]  code;
    logic [2:0]  free;
    logic        hv;
    logic [19:0] head;
  } vec_t;

  // inputs before the edge, expected outputs after it
  localparam vec_t VEC [19] = '{
    '{1'b1,1'b1,1'b0,20'hA0001,2'b00,3'd3,1'b1,20'hA0001},
    '{1'b1,1'b1,1'b0,20'hA0002,2'b00,3'd2,1'b1,20'hA0001},
    '{1'b1,1'b0,1'b0,20'hA0003,2'b10,3'd2,1'b1,20'hA0001},
    '{1'b1,1'b1,1'b0,20'hA0004,2'b00,3'd1,1'b1,20'hA0001},
    '{1'b1,1'b1,1'b0,20'hFFFFF,2'b00,3'd0,1'b1,20'hA0001},
    '{1'b1,1'b1,1'b0,20'hA0006,2'b01,3'd0,1'b1,20'hA0001},
    '{1'b1,1'b1,1'b1,20'hA0007,2'b00,3'd0,1'b1,20'hA0002},
    '{1'b0,1'b0,1'b1,20'h00000,2'b00,3'd1,1'b1,20'hA0004},
    '{1'b1,1'b1,1'b1,20'hA0009,2'b00,3'd1,1'b1,20'hFFFFF}, // R10
    '{1'b0,1'b0,1'b1,20'h00000,2'b00,3'd2,1'b1,20'hA0007},
    '{1'b0,1'b0,1'b1,20'h00000,2'b00,3'd3,1'b1,20'hA0009},
    '{1'b0,1'b0,1'b1,20'h00000,2'b00,3'd4,1'b0,20'h00000},
    '{1'b1,1'b0,1'b0,20'hB0000,2'b10,3'd4,1'b0,20'h00000},
    '{1'b1,1'b1,1'b0,20'hB0001,2'b00,3'd3,1'b1,20'hB0001},
    '{1'b1,1'b1,1'b0,20'hB0002,2'b00,3'd2,1'b1,20'hB0001},
    '{1'b1,1'b1,1'b0,20'hB0003,2'b00,3'd1,1'b1,20'hB0001},
    '{1'b1,1'b1,1'b0,20'hB0004,2'b00,3'd0,1'b1,20'hB0001},
    '{1'b1,1'b0,1'b0,20'hB0005,2'b10,3'd0,1'b1,20'hB0001},
    '{1'b1,1'b1,1'b0,20'hB0006,2'b01,3'd0,1'b1,20'hB0001}
  };

  function automatic logic [7:0]  op_of(logic [19:0] p);  return p[7:0] ^ 8'h5A; endfunction
  function automatic logic [63:0] par_of(logic [19:0] p); return {44'h0, p} + 64'h1000; endfunction
  function automatic logic [63:0] cmp_of(logic [19:0] p); return {p, 44'h00000_0000C}; endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(logic s, logic ok, logic r, logic [19:0] p);
    sub_valid = s; sub_pasid_ok = ok; dq_ready = r; sub_pasid = p;
    sub_op = op_of(p); sub_param_addr = par_of(p); sub_cmpl_addr = cmp_of(p);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk("R9 reset st_valid", st_valid, 0);
    chk("R9 reset dq_valid", dq_valid, 0);
    chk("R9 reset free_slots", free_slots, D);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 19; i++) begin
      string tag;
      @(negedge clk);
      drive(VEC[i].sub, VEC[i].ok, VEC[i].rdy, VEC[i].pasid);
      @(posedge clk); #5;
      chk("R1 status strobe", st_valid, VEC[i].sub);
      if (VEC[i].sub) begin
        if (!VEC[i].ok)                tag = "R3 status code";
        else if (VEC[i].code == 2'b01) tag = "R4 status code";
        else if (i == 6)               tag = "R5 status code";
        else                           tag = "R2 status code";
        chk(tag, st_code, VEC[i].code);
      end
      chk("R8 free_slots", free_slots, VEC[i].free);
      chk("R7 dq_valid", dq_valid, VEC[i].hv);
      if (VEC[i].hv) chk("R6 head pasid", dq_pasid, VEC[i].head);
    end

    // R6: drain the full queue, all fields in order
    for (int k = 1; k <= 4; k++) begin
      logic [19:0] p;
      p = 20'hB0000 + 20'(k);
      @(negedge clk);
      drive(1'b0, 1'b0, 1'b1, 20'h0);
      chk("R6 drain pasid", dq_pasid, p);
      chk("R6 drain op", dq_op, op_of(p));
      chk("R6 drain param addr", dq_param_addr, par_of(p));
      chk("R6 drain cmpl addr", dq_cmpl_addr, cmp_of(p));
    end
    @(posedge clk); #5;
    chk("R7 empty after drain", dq_valid, 0);

    // R9: reset with entries queued
    @(negedge clk); drive(1'b1, 1'b1, 1'b0, 20'hC0001);
    @(negedge clk); drive(1'b1, 1'b1, 1'b0, 20'hC0002);
    @(negedge clk); drive(1'b0, 1'b0, 1'b0, 20'h0);
    chk("R8 two queued", free_slots, D - 2);
    rst_n = 1'b0;
    @(posedge clk); #5;
    chk("R9 mid reset free_slots", free_slots, D);
    chk("R9 mid reset dq_valid", dq_valid, 0);
    chk("R9 mid reset st_valid", st_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #5;
    chk("R1 no strobe no status", st_valid, 0);

    finish_run();
  end
endmodule